// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers the event pulses that a USB device controller produces and holds them in a 9-bit interrupt status register. The sources are four IN endpoints, four OUT endpoints and the endpoint-0 control logic. Each status bit is set only under its own qualified conditions. IN enables are watched for a rising edge. A flush counts only when the IN FIFO holds packets. Underrun and overrun count only on endpoints marked isochronous. Each bit stays set until software clears it.

A per-bit enable mask selects which flags may interrupt the CPU. A single registered, level-sensitive request stays high while any enabled flag is set. Software reaches both registers through a small register port. A write to the status address clears every bit written as 1. Events can keep arriving while software services earlier ones. If an event and a clear reach the same bit in the same cycle, the event wins, so no event is lost. The external active-low reset is applied asynchronously and released synchronously inside the block.

Top module: `ep_irq_hub`

## Requirements
- R1: Status layout: IN endpoint n (n = 0..3) is bit 2n, OUT endpoint n is bit 2n+1, and bit 8 is the shared error flag. `reg_rdata` shows the status when `reg_addr` = 0 and the mask when `reg_addr` = 1.
- R2: An IN bit is set in the cycle after its `ep_en` input goes from 0 to 1. Holding `ep_en` at 1 does not set the bit again.
- R3: An IN bit is set by a pulse on `in_tx_done` or `in_ack_lost` for that endpoint.
- R4: An automatic or software flush sets the IN bit only when that endpoint's 2-bit field of `in_fifo_pkts` (bits 2n+1:2n) is nonzero. A flush with a count of 0 leaves the status unchanged.
- R5: An OUT bit is set only by `out_rx_done` for that endpoint, and it never touches an even bit.
- R6: The error bit is set by `ep0_stall`, `ep0_setup_end`, any `out_stall` bit, or any `out_data_err` bit.
- R7: `in_underrun[n]` sets the error bit only when `iso_in[n]` = 1. `out_overrun[n]` sets the error bit only when `iso_out[n]` = 1. Otherwise these inputs are ignored.
- R8: A write to address 0 clears every status bit written as 1. Bits written as 0 keep their value. A status bit falls only through such a write.
- R9: When a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is the OR of (status AND mask), registered. It rises one cycle after an enabled bit sets and falls one cycle after the last enabled set bit clears.
- R11: After reset the status, the mask and `irq` are all 0.
- R12: A write to address 1 loads the mask. Status bits set regardless of the mask, and `irq` follows a mask change one cycle after the mask loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_en | input | 4 | IN endpoint enable levels |
| in_tx_done | input | 4 | IN transmit completed, per endpoint |
| in_ack_lost | input | 4 | Final ACK of a control read lost, per endpoint |
| in_auto_flush | input | 4 | Hardware flush of an IN FIFO |
| in_sw_flush | input | 4 | Software flush of an IN FIFO |
| in_fifo_pkts | input | 8 | Packets held in each IN FIFO, 2 bits per endpoint |
| out_rx_done | input | 4 | OUT reception completed, per endpoint |
| ep0_stall | input | 1 | Endpoint-0 force-stall event |
| ep0_setup_end | input | 1 | Endpoint-0 setup-end event |
| out_stall | input | 4 | OUT endpoint force-stall events |
| out_data_err | input | 4 | OUT endpoint data error events |
| in_underrun | input | 4 | IN FIFO underrun events |
| out_overrun | input | 4 | OUT FIFO overrun events |
| iso_in | input | 4 | IN endpoint is isochronous |
| iso_out | input | 4 | OUT endpoint is isochronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = mask |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
Single-source pulses are sent on every trigger input. This shows whether each source reaches its own bit position and no other, which separates IN bits from OUT bits and the error bit. Qualified triggers are driven on both sides of their qualifier: flush with zero and nonzero packet counts, underrun and overrun with the isochronous input low and high, and the enable held high versus toggled. This shows whether the gating exists at all. Clear writes are tried with partial bit patterns and in the same cycle as a set on the same bit, to tell a write-1-to-clear register from a plain load and to show which side wins a collision. The mask and `irq` are sampled cycle by cycle through rise and fall, which exposes a missing or extra register stage.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  parameter int EP_N  = 4;
  parameter int PKT_W = 2;
  localparam int STAT_W  = 2 * EP_N + 1;
  localparam int ERR_BIT = 2 * EP_N;
endpackage

// File: rtl/ep_irq_qual.sv
module ep_irq_qual #(
  parameter int EP_N  = ep_irq_pkg::EP_N,
  parameter int PKT_W = ep_irq_pkg::PKT_W,
  localparam int SW   = 2 * EP_N + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EP_N-1:0]   ep_en,
  input  logic [EP_N-1:0]   in_tx_done,
  input  logic [EP_N-1:0]   in_ack_lost,
  input  logic [EP_N-1:0]   in_auto_flush,
  input  logic [EP_N-1:0]   in_sw_flush,
  input  logic [EP_N*PKT_W-1:0] in_fifo_pkts,
  input  logic [EP_N-1:0]   out_rx_done,
  input  logic              ep0_stall,
  input  logic              ep0_setup_end,
  input  logic [EP_N-1:0]   out_stall,
  input  logic [EP_N-1:0]   out_data_err,
  input  logic [EP_N-1:0]   in_underrun,
  input  logic [EP_N-1:0]   out_overrun,
  input  logic [EP_N-1:0]   iso_in,
  input  logic [EP_N-1:0]   iso_out,
  output logic [SW-1:0]     set_vec
);
  logic [EP_N-1:0] en_prev_q;
  logic [EP_N-1:0] en_prev_d;
  logic            err_hit;

  always_comb en_prev_d = ep_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev_q <= '0;
    else        en_prev_q <= en_prev_d;
  end

  for (genvar g = 0; g < EP_N; g++) begin : g_ep
    logic pkts_present;
    logic flush_hit;
    logic en_rise;
    assign pkts_present = |in_fifo_pkts[g*PKT_W +: PKT_W];
    assign flush_hit    = (in_auto_flush[g] | in_sw_flush[g]) & pkts_present;
    assign en_rise      = ep_en[g] & ~en_prev_q[g];
    assign set_vec[2*g]   = en_rise | in_tx_done[g] | in_ack_lost[g] | flush_hit;
    assign set_vec[2*g+1] = out_rx_done[g];
  end

  always_comb begin
    err_hit = ep0_stall | ep0_setup_end | (|out_stall) | (|out_data_err)
            | (|(in_underrun & iso_in)) | (|(out_overrun & iso_out));
  end

  assign set_vec[SW-1] = err_hit;
endmodule

// File: rtl/ep_irq_flags.sv
module ep_irq_flags #(
  parameter int W = ep_irq_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status_q
);
  logic [W-1:0] status_d;

  // set term applied after the clear term: an event wins a collision
  always_comb status_d = (status_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/ep_irq_req.sv
module ep_irq_req #(
  parameter int W = ep_irq_pkg::STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] status,
  output logic [W-1:0] mask_q,
  output logic         irq
);
  logic [W-1:0] mask_d;
  logic         irq_d;

  always_comb begin
    mask_d = mask_wdata;
    irq_d  = |(status & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/ep_irq_hub.sv
module ep_irq_hub #(
  parameter int EP_N  = ep_irq_pkg::EP_N,
  parameter int PKT_W = ep_irq_pkg::PKT_W,
  localparam int SW   = 2 * EP_N + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EP_N-1:0]       ep_en,
  input  logic [EP_N-1:0]       in_tx_done,
  input  logic [EP_N-1:0]       in_ack_lost,
  input  logic [EP_N-1:0]       in_auto_flush,
  input  logic [EP_N-1:0]       in_sw_flush,
  input  logic [EP_N*PKT_W-1:0] in_fifo_pkts,
  input  logic [EP_N-1:0]       out_rx_done,
  input  logic                  ep0_stall,
  input  logic                  ep0_setup_end,
  input  logic [EP_N-1:0]       out_stall,
  input  logic [EP_N-1:0]       out_data_err,
  input  logic [EP_N-1:0]       in_underrun,
  input  logic [EP_N-1:0]       out_overrun,
  input  logic [EP_N-1:0]       iso_in,
  input  logic [EP_N-1:0]       iso_out,
  input  logic                  reg_wr,
  input  logic                  reg_addr,
  input  logic [SW-1:0]         reg_wdata,
  output logic [SW-1:0]         reg_rdata,
  output logic                  irq
);
  logic          rst_meta_q;
  logic          rst_sync_n;
  logic [SW-1:0] set_vec;
  logic [SW-1:0] clr_vec;
  logic [SW-1:0] status_q;
  logic [SW-1:0] mask_q;
  logic          mask_we;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    clr_vec   = (reg_wr && !reg_addr) ? reg_wdata : '0;
    mask_we   = reg_wr && reg_addr;
    reg_rdata = reg_addr ? mask_q : status_q;
  end

  ep_irq_qual #(.EP_N(EP_N), .PKT_W(PKT_W)) u_qual (
    .clk(clk), .rst_n(rst_sync_n), .ep_en(ep_en),
    .in_tx_done(in_tx_done), .in_ack_lost(in_ack_lost),
    .in_auto_flush(in_auto_flush), .in_sw_flush(in_sw_flush),
    .in_fifo_pkts(in_fifo_pkts), .out_rx_done(out_rx_done),
    .ep0_stall(ep0_stall), .ep0_setup_end(ep0_setup_end),
    .out_stall(out_stall), .out_data_err(out_data_err),
    .in_underrun(in_underrun), .out_overrun(out_overrun),
    .iso_in(iso_in), .iso_out(iso_out), .set_vec(set_vec)
  );

  ep_irq_flags #(.W(SW)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec),
    .clr_vec(clr_vec), .status_q(status_q)
  );

  ep_irq_req #(.W(SW)) u_req (
    .clk(clk), .rst_n(rst_sync_n), .mask_we(mask_we),
    .mask_wdata(reg_wdata), .status(status_q),
    .mask_q(mask_q), .irq(irq)
  );
endmodule

// File: rtl/ep_irq_hub_chk.sv
module ep_irq_hub_chk #(
  parameter int EP_N = ep_irq_pkg::EP_N,
  localparam int SW  = 2 * EP_N + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_addr,
  input logic [SW-1:0]   reg_wdata,
  input logic [EP_N-1:0] in_underrun,
  input logic [EP_N-1:0] out_overrun,
  input logic [EP_N-1:0] iso_in,
  input logic [EP_N-1:0] iso_out,
  input logic [SW-1:0]   set_vec,
  input logic [SW-1:0]   status_q,
  input logic [SW-1:0]   mask_q,
  input logic            irq
);
  logic [SW-1:0] wr_clr;
  assign wr_clr = (reg_wr && !reg_addr) ? reg_wdata : '0;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R9

  AST_CLR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(wr_clr)) == '0)); // R8

  AST_RISE_ONLY_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_q & ~$past(status_q)) & ~$past(set_vec)) == '0)); // R5

  AST_ISO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(in_underrun & iso_in)) || (|(out_overrun & iso_out))) |=> status_q[SW-1]); // R7

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_q & mask_q)))); // R10
endmodule

bind ep_irq_hub ep_irq_hub_chk #(.EP_N(EP_N)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_underrun(in_underrun), .out_overrun(out_overrun),
  .iso_in(iso_in), .iso_out(iso_out), .set_vec(set_vec),
  .status_q(status_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/ep_irq_hub_bench.sv
`timescale 1ns/1ps
module ep_irq_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ep_en, in_tx_done, in_ack_lost, in_auto_flush, in_sw_flush;
  logic [7:0] in_fifo_pkts;
  logic [3:0] out_rx_done, out_stall, out_data_err, in_underrun, out_overrun;
  logic [3:0] iso_in, iso_out;
  logic       ep0_stall, ep0_setup_end;
  logic       reg_wr, reg_addr;
  logic [8:0] reg_wdata, reg_rdata;
  logic       irq;
  int         vectors = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ep_irq_hub u_ep_irq_hub (
    .clk(clk), .rst_n(rst_n), .ep_en(ep_en), .in_tx_done(in_tx_done),
    .in_ack_lost(in_ack_lost), .in_auto_flush(in_auto_flush),
    .in_sw_flush(in_sw_flush), .in_fifo_pkts(in_fifo_pkts),
    .out_rx_done(out_rx_done), .ep0_stall(ep0_stall),
    .ep0_setup_end(ep0_setup_end), .out_stall(out_stall),
    .out_data_err(out_data_err), .in_underrun(in_underrun),
    .out_overrun(out_overrun), .iso_in(iso_in), .iso_out(iso_out),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [8:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [8:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0; reg_addr = 1'b0;
  endtask

  task automatic quiet();
    in_tx_done = '0; in_ack_lost = '0; in_auto_flush = '0; in_sw_flush = '0;
    out_rx_done = '0; out_stall = '0; out_data_err = '0;
    in_underrun = '0; out_overrun = '0; ep0_stall = 1'b0; ep0_setup_end = 1'b0;
  endtask

  task automatic t_reset();
    logic [8:0] v;
    rd(1'b0, v); check("R11 status after reset", v, 9'h000);
    rd(1'b1, v); check("R11 mask after reset", v, 9'h000);
    check("R11 irq after reset", {8'h0, irq}, 9'h000);
  endtask

  task automatic t_layout();
    logic [8:0] v;
    in_tx_done[2] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R3 tx done ep2 -> bit4 (R1)", v, 9'h010);
    wr(1'b0, 9'h1FF);
    out_rx_done[1] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R5 rx done ep1 -> bit3 only (R1)", v, 9'h008);
    wr(1'b0, 9'h1FF);
    in_ack_lost[3] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R3 ack lost ep3 -> bit6", v, 9'h040);
    wr(1'b0, 9'h1FF);
  endtask

  task automatic t_enable_edge();
    logic [8:0] v;
    ep_en[1] = 1'b1; step();
    rd(1'b0, v); check("R2 enable rise ep1 -> bit2", v, 9'h004);
    wr(1'b0, 9'h1FF);
    step(); step();
    rd(1'b0, v); check("R2 held enable does not set again", v, 9'h000);
    ep_en[1] = 1'b0; step();
    rd(1'b0, v); check("R2 enable fall does not set", v, 9'h000);
    ep_en[1] = 1'b1; step();
    rd(1'b0, v); check("R2 second enable rise sets", v, 9'h004);
    wr(1'b0, 9'h1FF);
  endtask

  task automatic t_flush();
    logic [8:0] v;
    in_fifo_pkts = 8'h00; in_sw_flush[0] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R4 flush of empty fifo ignored", v, 9'h000);
    in_fifo_pkts = 8'h02; in_auto_flush[0] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R4 auto flush with 2 packets", v, 9'h001);
    wr(1'b0, 9'h1FF);
    in_fifo_pkts = 8'h40; in_sw_flush[3] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R4 sw flush ep3 with 1 packet", v, 9'h040);
    wr(1'b0, 9'h1FF);
    in_fifo_pkts = 8'h00;
  endtask

  task automatic t_error();
    logic [8:0] v;
    ep0_stall = 1'b1; step(); quiet();
    rd(1'b0, v); check("R6 ep0 stall -> bit8", v, 9'h100);
    wr(1'b0, 9'h1FF);
    ep0_setup_end = 1'b1; step(); quiet();
    rd(1'b0, v); check("R6 ep0 setup end -> bit8", v, 9'h100);
    wr(1'b0, 9'h1FF);
    out_stall[2] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R6 out stall -> bit8", v, 9'h100);
    wr(1'b0, 9'h1FF);
    out_data_err[3] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R6 out data error -> bit8", v, 9'h100);
    wr(1'b0, 9'h1FF);
  endtask

  task automatic t_iso();
    logic [8:0] v;
    iso_in = 4'h0; in_underrun[0] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R7 underrun on non-iso ignored", v, 9'h000);
    iso_in = 4'h1; in_underrun[0] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R7 underrun on iso sets error", v, 9'h100);
    wr(1'b0, 9'h1FF);
    iso_out = 4'hB; out_overrun[2] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R7 overrun on non-iso ignored", v, 9'h000);
    iso_out = 4'h4; out_overrun[2] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R7 overrun on iso sets error", v, 9'h100);
    wr(1'b0, 9'h1FF);
    iso_in = '0; iso_out = '0;
  endtask

  task automatic t_w1c();
    logic [8:0] v;
    in_tx_done[0] = 1'b1; out_rx_done[0] = 1'b1; ep0_stall = 1'b1; step(); quiet();
    rd(1'b0, v); check("R1 three sources at once", v, 9'h103);
    wr(1'b0, 9'h002);
    rd(1'b0, v); check("R8 clear bit1 only", v, 9'h101);
    wr(1'b0, 9'h000);
    rd(1'b0, v); check("R8 zero write keeps bits", v, 9'h101);
    wr(1'b1, 9'h000);
    rd(1'b0, v); check("R8 mask write leaves status", v, 9'h101);
    wr(1'b0, 9'h1FF);
    rd(1'b0, v); check("R8 clear all", v, 9'h000);
  endtask

  task automatic t_setwins();
    logic [8:0] v;
    in_tx_done[2] = 1'b1; in_tx_done[0] = 1'b1; step(); quiet();
    in_tx_done[2] = 1'b1;
    wr(1'b0, 9'h011);
    quiet();
    rd(1'b0, v); check("R9 set wins over same-cycle clear", v, 9'h010);
    wr(1'b0, 9'h1FF);
  endtask

  task automatic t_irq();
    logic [8:0] v;
    out_rx_done[1] = 1'b1; step(); quiet();
    rd(1'b0, v); check("R12 status sets while masked", v, 9'h008);
    step();
    check("R12 irq low while masked", {8'h0, irq}, 9'h000);
    wr(1'b1, 9'h028);
    rd(1'b1, v); check("R1 mask readback", v, 9'h028);
    check("R12 irq not yet after mask load", {8'h0, irq}, 9'h000);
    step();
    check("R12 irq one cycle after mask load", {8'h0, irq}, 9'h001);
    out_rx_done[2] = 1'b1; step(); quiet();
    wr(1'b0, 9'h008);
    step();
    check("R10 irq held while bit5 set", {8'h0, irq}, 9'h001);
    wr(1'b0, 9'h020);
    check("R10 irq still high in clear cycle", {8'h0, irq}, 9'h001);
    step();
    check("R10 irq falls after last clear", {8'h0, irq}, 9'h000);
    out_rx_done[1] = 1'b1; step(); quiet();
    check("R10 irq low in cycle status sets", {8'h0, irq}, 9'h000);
    step();
    check("R10 irq rises one cycle later", {8'h0, irq}, 9'h001);
    wr(1'b0, 9'h1FF); step();
  endtask

  initial begin
    rst_n = 1'b0; ep_en = '0; in_fifo_pkts = '0; iso_in = '0; iso_out = '0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    quiet();
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_layout();
    t_enable_edge();
    t_flush();
    t_error();
    t_iso();
    t_w1c();
    t_setwins();
    t_irq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule